// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent down-counters behind a byte-wide register port with a two-bit address. Addresses 0, 1 and 2 reach the counters. Address 3 is a write-only control register. A control word picks a counter and sets four things for it: how its bytes are transferred, its operating mode, and whether it counts in binary or in BCD. Each counter has a tick input, a gate input and an output pin. The tick inputs are count-enable strobes, synchronous to the system clock.

Two counting behaviours are built. The first is a one-shot terminal-count flag, in which the output rises when the count reaches zero. The second is a periodic rate generator, in which the output drops for one tick period on each cycle and the count then reloads itself. Software can freeze a running count for reading without stopping the counter. A readback command can freeze the counts of several counters at once, their status bytes, or both. Each frozen value stays until it has been read out.

Top module: `pit_top`

## Requirements
- R1: The control word is decoded as follows. Bits 7:6 select counter 0 to 2; the value 11 marks a readback command. Bits 5:4 select access: 00 latches the count, 01 transfers the low byte only, 10 the high byte only, and 11 the low byte then the high byte. Bits 3:1 are the mode and bit 0 selects BCD counting. Programming a counter resets both of its byte-sequence flip-flops and drops any pending latches. A read of address 3 returns 0x00. After reset every output is high and read data is 0x00.
- R2: With low-only access, a write loads the byte as the low byte and zero as the high byte. With high-only access, the byte goes to the high byte and zero to the low byte. A read returns only the selected byte.
- R3: With two-byte access, writes and reads each alternate: low byte first, then high byte. A new count is taken only after its high byte is written.
- R4: A completed count write is copied into the counter on that counter's next tick. The gate does not block this copy. Status bit 6 (null count) reads 1 from the completed write until that copy is made, and 0 afterwards.
- R5: In interval mode, the output goes low when the counter is programmed and when a count is written. It stays low while counting down. It rises when a decrement reaches zero, and then stays high while the count wraps and keeps counting.
- R6: In rate-generator mode, the output is high after programming. It goes low on the tick that brings the count to 1. On the next tick the output returns high and the written count is reloaded.
- R7: While a counter's gate is low, ticks do not decrement it.
- R8: In BCD mode, each 4-bit digit steps from 0 to 9 with a borrow into the next digit. A written count of zero acts as the largest count, so the first decrement gives 0x9999 in BCD and 0xFFFF in binary.
- R9: A latch command (access field 00) copies the live count into a hold register while counting continues. Reads return the held bytes until the programmed byte sequence is complete. Further latch commands to that counter are ignored until then.
- R10: The readback command is 11, then a count bit, then a status bit, then the select bits for counters 2, 1 and 0 in bits 3 to 1. A zero count bit latches the counts of all selected counters on the same clock edge.
- R11: A zero status bit in a readback latches each selected counter's status byte. The status byte holds, from bit 7 down: output level, null count, access field, mode field, BCD bit. The next read of that counter returns this byte once; the latched count bytes follow.
- R12: A mode field whose two low bits are 10 (2 or 6) selects the rate generator. Every other mode value selects interval mode. The status byte reports the mode field exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; ignored when wr_en is also high |
| addr | input | 2 | Register address: 0 to 2 are counters, 3 is control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, registered, valid the cycle after rd_en |
| tick | input | 3 | Per-counter count strobe |
| gate | input | 3 | Per-counter count enable level |
| tmr_out | output | 3 | Per-counter output pin |

## Verification
The hardest case to reach is a readback that latches both status and count for two counters in different modes. The counters must then keep ticking before the reads, so that the held values can be told apart from the live ones. The stimulus programs one counter in interval mode and one as a rate generator, loads both with a shared tick, and steps them together. It then issues one readback command and ticks again. Finally it reads each counter three times: the status byte first, then the two frozen count bytes. The null-count bit is reached by reading status between a count write and the tick that takes the count in, and again after that tick.

// File: rtl/pit_pkg.sv
// Package: shared widths and the down-step function of the timer.
// Assumes the count width is a multiple of four so that BCD digits tile it.
package pit_pkg;
    localparam int CNT_W    = 16;
    localparam int NUM_CH   = 3;
    localparam int DIGITS   = CNT_W / 4;
    localparam int BYTE_W   = 8;

    localparam logic [1:0] ACC_LATCH = 2'b00;
    localparam logic [1:0] ACC_LO    = 2'b01;
    localparam logic [1:0] ACC_HI    = 2'b10;
    localparam logic [1:0] ACC_BOTH  = 2'b11;

    // One decrement step in binary or packed-BCD arithmetic.
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                   input logic bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        if (!bcd) begin
            r = v - 1'b1;
        end else begin
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow) begin
                    if (v[d*4 +: 4] == 4'd0) begin
                        r[d*4 +: 4] = 4'd9;
                    end else begin
                        r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pit_decode.sv
// Module: pit_decode
// Turns one bus access into per-counter strobes: program, write, read,
// count latch and status latch. Purely combinational.
// Assumes a write wins over a read presented in the same cycle.
module pit_decode
    import pit_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] prog,
    output logic [NUM_CH-1:0] wr_ch,
    output logic [NUM_CH-1:0] rd_ch,
    output logic [NUM_CH-1:0] lat_cnt,
    output logic [NUM_CH-1:0] lat_sta
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic is_ctrl;
    logic is_rback;
    assign is_ctrl  = wr_en && (addr == CTRL_ADDR);
    assign is_rback = is_ctrl && (wdata[7:6] == 2'b11);

    // Per-counter strobe generation from address and control byte.
    always_comb begin
        prog    = '0;
        wr_ch   = '0;
        rd_ch   = '0;
        lat_cnt = '0;
        lat_sta = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            wr_ch[i] = wr_en && (addr == 2'(i));
            rd_ch[i] = rd_en && !wr_en && (addr == 2'(i));
            if (is_rback) begin
                lat_cnt[i] = wdata[i+1] && !wdata[5];
                lat_sta[i] = wdata[i+1] && !wdata[4];
            end else if (is_ctrl && (wdata[7:6] == 2'(i))) begin
                lat_cnt[i] = (wdata[5:4] == ACC_LATCH);
                prog[i]    = (wdata[5:4] != ACC_LATCH);
            end
        end
    end
endmodule

// File: rtl/pit_count_core.sv
// Module: pit_count_core
// Count element and output pin of one counter. A written count is taken on
// the next tick; afterwards ticks decrement while the gate is high.
// Assumes tick is a one-cycle strobe synchronous to clk.
module pit_count_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             prog,
    input  logic             prog_m2,
    input  logic             mode2,
    input  logic             bcd,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             out,
    output logic             loaded
);
    logic [CNT_W-1:0] ce_q;
    logic             out_q;
    logic             pend_q;
    logic             armed_q;

    assign count  = ce_q;
    assign out    = out_q;
    assign loaded = tick && pend_q && !prog;

    // Count element, pending-load flag and output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= '0;
            out_q   <= 1'b1;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (prog) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            out_q   <= prog_m2;
        end else begin
            if (load) begin
                pend_q <= 1'b1;
                if (!mode2) out_q <= 1'b0;
            end
            if (tick && pend_q) begin
                ce_q    <= reload;
                pend_q  <= load;
                armed_q <= 1'b1;
            end else if (tick && armed_q && gate && !load) begin
                if (mode2 && ce_q == CNT_W'(1)) begin
                    ce_q  <= reload;
                    out_q <= 1'b1;
                end else begin
                    ce_q <= step_down(ce_q, bcd);
                    if (mode2 && ce_q == CNT_W'(2)) out_q <= 1'b0;
                    if (!mode2 && ce_q == CNT_W'(1)) out_q <= 1'b1;
                end
            end
        end
    end

    // R5: in interval mode the output only rises when the count hits zero
    a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode2 && $rose(out_q)) |-> (ce_q == '0));

    // R6: in rate-generator mode the output only falls when the count is one
    a_r6_low_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        (mode2 && $fell(out_q)) |-> (ce_q == CNT_W'(1)));

    // R7: a low gate with no pending load freezes the count
    a_r7_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !pend_q) |=> $stable(ce_q));
endmodule

// File: rtl/pit_channel.sv
// Module: pit_channel
// One timer channel: configuration, count register, byte-sequence
// flip-flops, count and status hold registers, and the read byte select.
// Assumes at most one bus strobe reaches it per cycle.
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              wr,
    input  logic              rd,
    input  logic              lat_cnt,
    input  logic              lat_sta,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  logic              gate,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out
);
    logic [1:0]       acc_q;
    logic [2:0]       mode_q;
    logic             bcd_q;
    logic [CNT_W-1:0] cr_q;
    logic             wr_hi_q;
    logic             rd_hi_q;
    logic [CNT_W-1:0] cnt_hold_q;
    logic             cnt_held_q;
    logic [BYTE_W-1:0] sta_hold_q;
    logic             sta_held_q;
    logic             null_q;

    logic [CNT_W-1:0] count;
    logic             loaded;
    logic             load_evt;
    logic             mode2;
    logic [CNT_W-1:0] src;
    logic             rd_last;

    assign mode2    = (mode_q[1:0] == 2'b10);
    assign load_evt = wr && (acc_q != ACC_LATCH) && ((acc_q != ACC_BOTH) || wr_hi_q);
    assign src      = cnt_held_q ? cnt_hold_q : count;
    assign rd_last  = (acc_q != ACC_BOTH) || rd_hi_q;

    pit_count_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .gate    (gate),
        .prog    (prog),
        .prog_m2 (wdata[2:1] == 2'b10),
        .mode2   (mode2),
        .bcd     (bcd_q),
        .load    (load_evt),
        .reload  (cr_q),
        .count   (count),
        .out     (out),
        .loaded  (loaded)
    );

    // Read byte select: status first, then held or live count bytes.
    always_comb begin
        if (sta_held_q)                                    rd_byte = sta_hold_q;
        else if (acc_q == ACC_HI || (acc_q == ACC_BOTH && rd_hi_q)) rd_byte = src[15:8];
        else                                               rd_byte = src[7:0];
    end

    // Configuration, count register, sequencing and hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_BOTH;
            mode_q     <= '0;
            bcd_q      <= 1'b0;
            cr_q       <= '0;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            cnt_hold_q <= '0;
            cnt_held_q <= 1'b0;
            sta_hold_q <= '0;
            sta_held_q <= 1'b0;
            null_q     <= 1'b0;
        end else if (prog) begin
            acc_q      <= wdata[5:4];
            mode_q     <= wdata[3:1];
            bcd_q      <= wdata[0];
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            cnt_held_q <= 1'b0;
            sta_held_q <= 1'b0;
            null_q     <= 1'b1;
        end else begin
            if (wr) begin
                case (acc_q)
                    ACC_LO: cr_q <= {8'h00, wdata};
                    ACC_HI: cr_q <= {wdata, 8'h00};
                    ACC_BOTH: begin
                        if (wr_hi_q) cr_q[15:8] <= wdata;
                        else         cr_q[7:0]  <= wdata;
                        wr_hi_q <= !wr_hi_q;
                    end
                    default: ;
                endcase
            end
            if (load_evt)    null_q <= 1'b1;
            else if (loaded) null_q <= 1'b0;
            if (lat_cnt && !cnt_held_q) begin
                cnt_hold_q <= count;
                cnt_held_q <= 1'b1;
            end
            if (lat_sta && !sta_held_q) begin
                sta_hold_q <= {out, null_q, acc_q, mode_q, bcd_q};
                sta_held_q <= 1'b1;
            end
            if (rd) begin
                if (sta_held_q) begin
                    sta_held_q <= 1'b0;
                end else begin
                    if (acc_q == ACC_BOTH) rd_hi_q <= !rd_hi_q;
                    if (rd_last)           cnt_held_q <= 1'b0;
                end
            end
        end
    end

    // R9: a held count never changes until it has been read out
    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_held_q |=> $stable(cnt_hold_q));

    // R11: a latched status byte is returned by exactly one read
    a_r11_status_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sta_held_q) |=> !sta_held_q);
endmodule

// File: rtl/pit_top.sv
// Module: pit_top
// Three-channel interval timer with a byte register port. Address 3 takes
// control words and readback commands; addresses 0..2 reach the counters.
// Assumes all inputs are synchronous to clk; read data is registered.
module pit_top
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [NUM_CH-1:0] tick,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] tmr_out
);
    logic [NUM_CH-1:0] prog, wr_ch, rd_ch, lat_cnt, lat_sta;
    logic [BYTE_W-1:0] ch_byte [NUM_CH];

    pit_decode u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .prog    (prog),
        .wr_ch   (wr_ch),
        .rd_ch   (rd_ch),
        .lat_cnt (lat_cnt),
        .lat_sta (lat_sta)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pit_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .prog    (prog[i]),
            .wr      (wr_ch[i]),
            .rd      (rd_ch[i]),
            .lat_cnt (lat_cnt[i]),
            .lat_sta (lat_sta[i]),
            .wdata   (wdata),
            .tick    (tick[i]),
            .gate    (gate[i]),
            .rd_byte (ch_byte[i]),
            .out     (tmr_out[i])
        );
    end

    // Registered read data mux; the control address reads as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en && !wr_en) begin
            rdata <= (addr < 2'(NUM_CH)) ? ch_byte[addr] : '0;
        end
    end

    // R1: reading the control address returns zero
    a_r1_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 2'd3) |=> (rdata == 8'h00));
endmodule

// File: tb/tb_pit_top.sv
// Directed bench for pit_top: one task per scenario, each checking itself.
module tb_pit_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] tick = '0, gate = 3'b111;
    logic [2:0] tmr_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pit_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick),
                 .gate(gate), .tmr_out(tmr_out));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pulse(input logic [2:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = m;
            @(negedge clk); tick = '0;
        end
    endtask

    task automatic rd16(input logic [1:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a, hi); v = {hi, lo};
    endtask

    task automatic t_reset;
        logic [7:0] b;
        chk("R1 reset outputs", {13'd0, tmr_out}, 16'h0007);
        chk("R1 reset rdata", {8'd0, rdata}, 16'h0000);
        rd(2'd3, b);
        chk("R1 control reads zero", {8'd0, b}, 16'h0000);
    endtask

    task automatic t_mode0;
        logic [15:0] v;
        wr(2'd3, 8'h30);
        @(negedge clk);
        chk("R5 out low after program", {15'd0, tmr_out[0]}, 16'h0);
        wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        pulse(3'b001, 1);
        rd16(2'd0, v);
        chk("R3 two-byte live read", v, 16'h0005);
        pulse(3'b001, 4);
        chk("R5 out low at count 1", {15'd0, tmr_out[0]}, 16'h0);
        pulse(3'b001, 1);
        chk("R5 out high at zero", {15'd0, tmr_out[0]}, 16'h1);
        pulse(3'b001, 1);
        chk("R5 out stays high after wrap", {15'd0, tmr_out[0]}, 16'h1);
    endtask

    task automatic t_gate;
        logic [15:0] v;
        wr(2'd3, 8'h70);
        wr(2'd1, 8'h0A); wr(2'd1, 8'h00);
        gate[1] = 1'b0;
        pulse(3'b010, 4);
        rd16(2'd1, v);
        chk("R7 gate low holds count", v, 16'h000A);
        gate[1] = 1'b1;
        pulse(3'b010, 3);
        rd16(2'd1, v);
        chk("R7 gate high counts", v, 16'h0007);
    endtask

    task automatic t_mode2;
        wr(2'd3, 8'hB4);
        @(negedge clk);
        chk("R6 out high after program", {15'd0, tmr_out[2]}, 16'h1);
        wr(2'd2, 8'h03); wr(2'd2, 8'h00);
        pulse(3'b100, 2);
        chk("R6 high at count 2", {15'd0, tmr_out[2]}, 16'h1);
        pulse(3'b100, 1);
        chk("R6 low at count 1", {15'd0, tmr_out[2]}, 16'h0);
        pulse(3'b100, 1);
        chk("R6 high after reload", {15'd0, tmr_out[2]}, 16'h1);
        pulse(3'b100, 2);
        chk("R6 low again next period", {15'd0, tmr_out[2]}, 16'h0);
    endtask

    task automatic t_modesel;
        logic [7:0] b;
        wr(2'd3, 8'hBC);
        @(negedge clk);
        chk("R12 mode 6 acts as rate generator", {15'd0, tmr_out[2]}, 16'h1);
        wr(2'd3, 8'hE8);
        rd(2'd2, b);
        chk("R12 status keeps mode 6", {8'd0, b}, 16'h00FC);
        wr(2'd3, 8'h38);
        @(negedge clk);
        chk("R12 mode 4 acts as interval", {15'd0, tmr_out[0]}, 16'h0);
    endtask

    task automatic t_latch;
        logic [7:0] b;
        logic [15:0] v;
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h03); wr(2'd0, 8'h02);
        pulse(3'b001, 3);
        wr(2'd3, 8'h00);
        pulse(3'b001, 3);
        wr(2'd3, 8'h00);
        rd(2'd0, b);
        chk("R9 held low byte", {8'd0, b}, 16'h0001);
        pulse(3'b001, 1);
        rd(2'd0, b);
        chk("R9 held high byte, second latch ignored", {8'd0, b}, 16'h0002);
        rd16(2'd0, v);
        chk("R9 live count after hold read", v, 16'h01FD);
    endtask

    task automatic t_single;
        logic [7:0] b;
        wr(2'd3, 8'h50);
        wr(2'd1, 8'h37);
        pulse(3'b010, 1);
        rd(2'd1, b);
        chk("R2 low-only load and read", {8'd0, b}, 16'h0037);
        wr(2'd3, 8'h60);
        wr(2'd1, 8'h12);
        pulse(3'b010, 2);
        rd(2'd1, b);
        chk("R2 high-only load, low byte zero", {8'd0, b}, 16'h0011);
    endtask

    task automatic t_bcd;
        logic [15:0] v;
        wr(2'd3, 8'h31);
        wr(2'd0, 8'h00); wr(2'd0, 8'h10);
        pulse(3'b001, 2);
        rd16(2'd0, v);
        chk("R8 BCD borrow 1000 to 0999", v, 16'h0999);
        wr(2'd0, 8'h00); wr(2'd0, 8'h00);
        pulse(3'b001, 2);
        rd16(2'd0, v);
        chk("R8 BCD zero is max count", v, 16'h9999);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h00); wr(2'd0, 8'h00);
        pulse(3'b001, 2);
        rd16(2'd0, v);
        chk("R8 binary zero is max count", v, 16'hFFFF);
        chk("R8 out low at max count", {15'd0, tmr_out[0]}, 16'h0);
    endtask

    task automatic t_readback;
        logic [7:0] b;
        logic [15:0] v;
        wr(2'd3, 8'h30); wr(2'd0, 8'h20); wr(2'd0, 8'h00);
        wr(2'd3, 8'h74); wr(2'd1, 8'h10); wr(2'd1, 8'h00);
        pulse(3'b011, 3);
        wr(2'd3, 8'hC6);
        pulse(3'b011, 1);
        rd(2'd0, b);
        chk("R11 status first counter 0", {8'd0, b}, 16'h0030);
        rd16(2'd0, v);
        chk("R10 counter 0 held count", v, 16'h001E);
        rd(2'd1, b);
        chk("R11 status first counter 1", {8'd0, b}, 16'h00B4);
        rd16(2'd1, v);
        chk("R10 counter 1 held same edge", v, 16'h000E);
        wr(2'd3, 8'hB0); wr(2'd2, 8'h05); wr(2'd2, 8'h00);
        wr(2'd3, 8'hE8);
        rd(2'd2, b);
        chk("R4 null count set before load", {8'd0, b}, 16'h0070);
        pulse(3'b100, 1);
        wr(2'd3, 8'hE8);
        rd(2'd2, b);
        chk("R4 null count clear after load", {8'd0, b}, 16'h0030);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_gate();
        t_mode2();
        t_modesel();
        t_latch();
        t_single();
        t_bcd();
        t_readback();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule